// File: doc/BRIEF.md
# Radio Frame Position Start Pulse Generator

This block follows the transmit position inside a 10 ms radio frame with three nested counters. The innermost counts words within a basic frame. The middle one counts basic frames within a hyperframe. The outer one counts hyperframes within the radio frame. A word-advance strobe steps the position by one word, and a radio-frame boundary pulse returns all three counters to zero.

A packed 24-bit start-offset value names one position as a hyperframe, a basic frame and a word. When the counters land on that position, the block raises a one-cycle transmit-start pulse. A data source waits for this pulse and then starts feeding payload. The offset is usually set a little ahead of the slot the payload should occupy, so that the buffers further down the path have time to fill.

The pulse fires at most once per radio frame. It is re-armed only by the boundary pulse.

Top module: `frame_pos_start_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `word_idx`, `bf_idx` and `hf_idx` are zero and `tx_start` is low.
- R2: A clock edge with `word_adv` high and `rf_boundary` low increments `word_idx`. From `WORDS_PER_BF-1` it returns to 0 and carries into the basic frame counter.
- R3: `bf_idx` advances only on a word carry. It wraps from `BF_PER_HF-1` (default 255) to 0 and carries into the hyperframe counter.
- R4: `hf_idx` advances only on a basic frame carry and wraps from `HF_PER_RF-1` (default 149) to 0.
- R5: A clock edge with `rf_boundary` high clears all three counters, even when `word_adv` is also high.
- R6: An edge with both `word_adv` and `rf_boundary` low leaves all three counters unchanged.
- R7: The offset fields sit at these bit positions: basic frame in bits [7:0], hyperframe in bits [15:8], word in bits [23:16]. For example, 0x000595FE names word 5 of basic frame 254 of hyperframe 149.
- R8: `tx_start` is high for exactly the cycle in which the counters first show the programmed position after an advance. It therefore rises on the same edge that updates the counters.
- R9: After a pulse, no further pulse occurs until the next `rf_boundary`. This holds even if the counters wrap and pass the same position again.
- R10: With an offset of zero, the pulse rises on the edge that applies `rf_boundary`.
- R11: The offset is compared on every edge. A value changed in the middle of a frame therefore takes effect at the next edge.
- R12: An offset whose word field is `WORDS_PER_BF` or larger never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_adv | input | 1 | Advance the position by one word |
| rf_boundary | input | 1 | Start of a radio frame; clears the position |
| start_offset | input | 24 | Packed target position: word [23:16], hyperframe [15:8], basic frame [7:0] |
| word_idx | output | 8 | Current word within the basic frame |
| bf_idx | output | 8 | Current basic frame within the hyperframe |
| hf_idx | output | 8 | Current hyperframe within the radio frame |
| tx_start | output | 1 | One-cycle pulse when the target position is reached |

## Verification
The bench runs with shrunken frame parameters, so that a complete radio frame plus a second lap fits in a short run.

Several targets are tried:
- A mid-frame target with distinct values in each field detects swapped field positions.
- A target of zero separates the boundary-edge firing from the advance-edge firing.
- The last position of the frame checks the full carry chain.
- A gapped advance pattern shows that idle cycles neither move the counters nor fire the pulse.
- An out-of-range word field must stay silent.

On every step, an independent position model is compared against all three counters and the pulse. The pass over the wrapped counters separates arming once per frame from firing on every match. Directed cases cover a boundary that arrives together with an advance, and an offset rewritten just before the position it names.

// File: rtl/frame_pos_pkg.sv
// Shared types for the radio frame position start pulse generator.
// Assumes every position field fits in FIELD_W bits.
package frame_pos_pkg;

    localparam int FIELD_W = 8;
    localparam int LEVELS  = 3;   // word, basic frame, hyperframe

    // Packed target position; bit layout matches the offset input.
    typedef struct packed {
        logic [FIELD_W-1:0] word;   // [23:16]
        logic [FIELD_W-1:0] hf;     // [15:8]
        logic [FIELD_W-1:0] bf;     // [7:0]
    } frame_pos_t;

endpackage

// File: rtl/wrap_counter.sv
// Modulo counter with a synchronous clear.
// Counts from 0 to MODULUS-1 and wraps to 0 on the next increment.
// Exposes the next-cycle value so that a comparator can look ahead.
// Assumes 1 <= MODULUS <= 2**W.
module wrap_counter #(
    parameter int MODULUS = 16,
    parameter int W       = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic [W-1:0] value_nxt
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    // Next-state selection: clear wins over increment.
    always_comb begin
        if (clear)
            value_nxt = '0;
        else if (inc)
            value_nxt = (value == LAST) ? '0 : value + 1'b1;
        else
            value_nxt = value;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else
            value <= value_nxt;
    end

endmodule

// File: rtl/start_match.sv
// Compares the look-ahead position with the target position and emits a
// one-cycle start pulse.
// The pulse fires at most once per radio frame. An arm flag is set by the
// frame boundary and cleared by a pulse.
// Assumes next_pos is the value the counters take on this edge.
module start_match
    import frame_pos_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rf_boundary,
    input  logic       word_adv,
    input  frame_pos_t next_pos,
    input  frame_pos_t target,
    output logic       tx_start
);

    logic armed_q;
    logic fire;

    // A pulse needs an edge that moves the position onto the target.
    always_comb begin
        fire = (rf_boundary || (word_adv && armed_q)) && (next_pos == target);
    end

    // Arm flag: re-armed by the boundary unless the boundary itself fires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (rf_boundary)
            armed_q <= !fire;
        else if (fire)
            armed_q <= 1'b0;
    end

    // Registered pulse, aligned with the counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_start <= 1'b0;
        else
            tx_start <= fire;
    end

endmodule

// File: rtl/frame_pos_start_gen.sv
// Top of the radio frame position start pulse generator.
// Three nested wrap counters (word, basic frame, hyperframe) follow the
// transmit position. A comparator fires tx_start when the position reaches
// start_offset.
// Assumes each modulus is between 1 and 256.
module frame_pos_start_gen
    import frame_pos_pkg::*;
#(
    parameter int WORDS_PER_BF = 16,
    parameter int BF_PER_HF    = 256,
    parameter int HF_PER_RF    = 150
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_adv,
    input  logic         rf_boundary,
    input  logic [23:0]  start_offset,
    output logic [7:0]   word_idx,
    output logic [7:0]   bf_idx,
    output logic [7:0]   hf_idx,
    output logic         tx_start
);

    localparam int LEVEL_MOD [LEVELS] = '{WORDS_PER_BF, BF_PER_HF, HF_PER_RF};

    logic [FIELD_W-1:0] cnt     [LEVELS];
    logic [FIELD_W-1:0] cnt_nxt [LEVELS];
    logic               inc     [LEVELS];
    frame_pos_t         next_pos;
    frame_pos_t         target;

    assign inc[0] = word_adv;

    // One counter per level; each carry feeds the level above it.
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        wrap_counter #(
            .MODULUS (LEVEL_MOD[g]),
            .W       (FIELD_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (rf_boundary),
            .inc       (inc[g]),
            .value     (cnt[g]),
            .value_nxt (cnt_nxt[g])
        );
        if (g < LEVELS - 1) begin : g_carry
            assign inc[g+1] = inc[g] && (cnt[g] == FIELD_W'(LEVEL_MOD[g] - 1));
        end
    end

    // Pack the look-ahead position and unpack the target fields.
    always_comb begin
        next_pos.word = cnt_nxt[0];
        next_pos.bf   = cnt_nxt[1];
        next_pos.hf   = cnt_nxt[2];
        target        = frame_pos_t'(start_offset);
    end

    start_match u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .rf_boundary (rf_boundary),
        .word_adv    (word_adv),
        .next_pos    (next_pos),
        .target      (target),
        .tx_start    (tx_start)
    );

    assign word_idx = cnt[0];
    assign bf_idx   = cnt[1];
    assign hf_idx   = cnt[2];

endmodule

// File: rtl/frame_pos_start_gen_chk.sv
// Assertion checker for frame_pos_start_gen, attached to it with bind.
module frame_pos_start_gen_chk #(
    parameter int WORDS_PER_BF = 16,
    parameter int BF_PER_HF    = 256,
    parameter int HF_PER_RF    = 150
) (
    input logic        clk,
    input logic        rst_n,
    input logic        word_adv,
    input logic        rf_boundary,
    input logic [23:0] start_offset,
    input logic [7:0]  word_idx,
    input logic [7:0]  bf_idx,
    input logic [7:0]  hf_idx,
    input logic        tx_start
);

    // R5: the boundary clears the position, even when an advance is present.
    p_boundary_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_boundary |=> (word_idx == 8'd0 && bf_idx == 8'd0 && hf_idx == 8'd0));

    // R6: with no strobe at all, the position holds.
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_adv && !rf_boundary) |=> $stable({word_idx, bf_idx, hf_idx}));

    // R2: a plain advance below the wrap point steps the word by one.
    p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_adv && !rf_boundary && int'(word_idx) != WORDS_PER_BF - 1)
        |=> word_idx == $past(word_idx) + 8'd1);

    // R8: the pulse appears only at the position named by the offset
    // sampled on the same edge.
    p_pulse_at_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> ({word_idx, hf_idx, bf_idx} == $past(start_offset)));

    // R9: there is no back-to-back pulse without a boundary in between.
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !rf_boundary) |=> !tx_start);

    // R2, R3, R4: the counters stay inside their moduli.
    always @(posedge clk) begin
        if (rst_n) begin
            p_range_r4: assert (int'(word_idx) < WORDS_PER_BF &&
                                int'(bf_idx) < BF_PER_HF &&
                                int'(hf_idx) < HF_PER_RF);
        end
    end

endmodule

bind frame_pos_start_gen frame_pos_start_gen_chk #(
    .WORDS_PER_BF (WORDS_PER_BF),
    .BF_PER_HF    (BF_PER_HF),
    .HF_PER_RF    (HF_PER_RF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_adv     (word_adv),
    .rf_boundary  (rf_boundary),
    .start_offset (start_offset),
    .word_idx     (word_idx),
    .bf_idx       (bf_idx),
    .hf_idx       (hf_idx),
    .tx_start     (tx_start)
);

// File: tb/frame_pos_start_gen_tb.sv
// Self-checking bench with shrunken frame sizes: 4 words, 8 basic frames,
// 5 hyperframes, so one radio frame is 160 advances.
module frame_pos_start_gen_tb;

    localparam int NW = 4;
    localparam int NB = 8;
    localparam int NH = 5;
    localparam int FRAME = NW * NB * NH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_adv = 1'b0;
    logic        rf_boundary = 1'b0;
    logic [23:0] start_offset = '0;
    logic [7:0]  word_idx, bf_idx, hf_idx;
    logic        tx_start;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Position model built from the requirements.
    int  mw = 0, mb = 0, mh = 0;
    bit  marmed = 1'b1;
    bit  exp_s  = 1'b0;
    int  pulses = 0;
    int  exp_pulses = 0;
    logic [23:0] pulse_pos = '0;

    always #4 clk = ~clk;   // 125 MHz

    frame_pos_start_gen #(
        .WORDS_PER_BF (NW),
        .BF_PER_HF    (NB),
        .HF_PER_RF    (NH)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_adv     (word_adv),
        .rf_boundary  (rf_boundary),
        .start_offset (start_offset),
        .word_idx     (word_idx),
        .bf_idx       (bf_idx),
        .hf_idx       (hf_idx),
        .tx_start     (tx_start)
    );

    // Table entries: bit 24 = gapped advance pattern, bits 23:0 = offset.
    localparam logic [24:0] VEC [5] = '{
        {1'b0, 24'h020305},   // R7, R8: distinct fields mid frame
        {1'b0, 24'h000000},   // R10, R9: zero target, then a wrap
        {1'b0, 24'h030407},   // R8: last position of the frame
        {1'b1, 24'h000100},   // R6: gapped advance
        {1'b1, 24'h040000}    // R12: word field out of range
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_match();
        return start_offset[23:16] == 8'(mw) && start_offset[15:8] == 8'(mh) &&
               start_offset[7:0] == 8'(mb);
    endfunction

    // Drive one cycle, advance the model, then check at the falling edge.
    task automatic step(input logic adv, input logic bnd);
        string ptag;
        string stag;
        word_adv    = adv;
        rf_boundary = bnd;
        @(posedge clk);
        stag = "R8";
        if (bnd) begin
            mw = 0; mb = 0; mh = 0;
            exp_s  = model_match();
            marmed = !exp_s;
            ptag = "R5"; stag = "R10";
        end else if (adv) begin
            mw++;
            if (mw == NW) begin
                mw = 0; mb++;
                if (mb == NB) begin
                    mb = 0; mh++;
                    if (mh == NH) mh = 0;
                end
            end
            if (int'(start_offset[23:16]) >= NW) stag = "R12";
            else if (!marmed && model_match()) stag = "R9";
            exp_s = marmed && model_match();
            if (exp_s) marmed = 1'b0;
            ptag = "R2";
        end else begin
            exp_s = 1'b0;
            ptag = "R6"; stag = "R6";
        end
        @(negedge clk);
        word_adv    = 1'b0;
        rf_boundary = 1'b0;
        check(word_idx == 8'(mw), ptag, word_idx, mw);
        check(bf_idx == 8'(mb), (ptag == "R2") ? "R3" : ptag, bf_idx, mb);
        check(hf_idx == 8'(mh), (ptag == "R2") ? "R4" : ptag, hf_idx, mh);
        check(tx_start == exp_s, stag, tx_start, exp_s);
        if (exp_s) exp_pulses++;
        if (tx_start) begin
            pulses++;
            pulse_pos = {word_idx, hf_idx, bf_idx};
        end
    endtask

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        check(word_idx == 0 && bf_idx == 0 && hf_idx == 0, "R1",
              {word_idx, bf_idx, hf_idx}, 0);
        check(tx_start == 1'b0, "R1", tx_start, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_idx == 0 && bf_idx == 0 && hf_idx == 0 && !tx_start, "R1",
              {tx_start, word_idx, bf_idx, hf_idx}, 0);

        // Table walk: one boundary, then a full frame plus part of a second lap.
        foreach (VEC[i]) begin
            start_offset = VEC[i][23:0];
            pulses = 0; exp_pulses = 0;
            step(1'b0, 1'b1);
            for (int k = 0; k < FRAME + 12; k++) begin
                if (VEC[i][24]) step(1'b0, 1'b0);
                step(1'b1, 1'b0);
            end
            check(pulses == exp_pulses, "R9", pulses, exp_pulses);
            if (i == 0) begin
                check(pulses == 1, "R7", pulses, 1);
                check(pulse_pos == 24'h020305, "R7", pulse_pos, 24'h020305);
            end
            if (i == 4) check(pulses == 0, "R12", pulses, 0);
        end

        // R5: a boundary together with an advance in the middle of a frame.
        start_offset = 24'h030000;
        step(1'b0, 1'b1);
        for (int k = 0; k < 9; k++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check(word_idx == 0 && bf_idx == 0 && hf_idx == 0, "R5",
              {word_idx, bf_idx, hf_idx}, 0);

        // R11: the offset is rewritten just before the position it names.
        start_offset = 24'h000003;
        step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        start_offset = 24'h030000;
        step(1'b1, 1'b0);
        check(tx_start == 1'b1, "R11", tx_start, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule